// File: doc/BRIEF.md
# Self-Synchronizing PRBS Error Detector

This block takes a serial bit stream, one bit per clock qualified by a valid strobe, and finds its place in a selected pseudorandom binary sequence on its own, with no reference from the sending side. While it is searching, it rebuilds the generator state from the received bits and tests each prediction against the next bit that arrives. Once a long enough run of predictions has matched, it runs its own generator freely and compares every valid bit with the bit it expects.

While locked, the block keeps saturating counts of compared bits and of errored bits. The error ratio is the second count divided by the first; that division is done outside the block. For each error it records where the errored bit sits within the pattern period. When errors become too dense, it drops lock, signals the loss for one cycle and starts the search again by itself.

Top module: `prbs_err_det`

## Requirements
- R1: `sel` picks the pattern, and each received bit b[n] is predicted from earlier bits: 0 gives PRBS7 (b[n]=b[n-7]^b[n-6]), 1 gives PRBS15 (b[n-15]^b[n-14]), 2 gives PRBS23 (b[n-23]^b[n-18]) and 3 gives PRBS31 (b[n-31]^b[n-28]).
- R2: After reset or a restart, the first N valid bits (N = the pattern order) only fill the history. `locked` rises in the cycle after the valid bit that completes 64 consecutive correct predictions. With clean data from reset this is valid bit N+64.
- R3: While searching, a mispredicted bit sets the match run back to zero, and the received bit still enters the history. A single flipped bit at index 20 of a PRBS7 stream therefore moves lock from bit 71 to bit 92.
- R4: While locked, the expected sequence comes only from the internal generator. Each flipped input bit therefore causes exactly one error, and the bits that follow it are unaffected.
- R5: `bit_cnt` rises by one for each valid bit compared while locked, and `err_cnt` rises by one for each of those bits that mismatches. Neither count moves while unlocked or while `in_valid` is low.
- R6: `clr_cnt` zeroes both counts in the next cycle and takes priority over an increment in the same cycle.
- R7: Both counts stop at all ones (CNT_W bits) instead of wrapping.
- R8: While locked, if the 64 most recent compared bits contain more than 16 errors, lock drops after that bit. `sync_lost` pulses for one cycle and acquisition restarts. Exactly 16 errors within the window keeps lock.
- R9: Each errored bit gives a one-cycle `err_flag` pulse and loads `err_pos` with that bit's position in the period. Position 0 is the bit whose N predecessors are all ones, and positions count up modulo 2^N-1. From reset, the history counts as all ones.
- R10: A change of `sel` drops lock at once and restarts acquisition; the valid bit in that cycle is ignored.
- R11: After reset, `locked`, `sync_lost`, `err_flag`, both counts and `err_pos` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Pattern select (0..3 = PRBS7/15/23/31) |
| clr_cnt | input | 1 | Zero both counters |
| in_valid | input | 1 | Qualifies `in_bit` |
| in_bit | input | 1 | Received serial bit |
| locked | output | 1 | Pattern lock held |
| sync_lost | output | 1 | One-cycle pulse on loss of lock |
| err_flag | output | 1 | One-cycle pulse per errored bit |
| bit_cnt | output | CNT_W | Compared bits while locked |
| err_cnt | output | CNT_W | Errored bits while locked |
| err_pos | output | 31 | Pattern position of the latest error |

## Verification
Every result is registered once after the edge that takes the valid bit. Lock, loss of lock, the error pulse, the error position and both counts are therefore all due one cycle after the bit that causes them. The bench applies each bit just after a rising edge and reads the outputs one edge later, so every check falls in the cycle in which its result is first visible. The lock instant is checked on both sides of the expected bit (bits 70 and 71, and bits 91 and 92 after a disturbed search). Loss of lock is checked at both the 16th and the 17th dense error.

// File: rtl/prbs_det_pkg.sv
package prbs_det_pkg;

    localparam int HIST_W = 31;

    typedef enum logic [1:0] {
        PAT_P7  = 2'd0,
        PAT_P15 = 2'd1,
        PAT_P23 = 2'd2,
        PAT_P31 = 2'd3
    } pat_sel_e;

    typedef enum logic {
        ST_ACQ  = 1'b0,
        ST_LOCK = 1'b1
    } sync_st_e;

    typedef struct packed {
        logic exp_bit;
        logic anchor;
    } pred_t;

    // history index of the oldest tap (order - 1)
    function automatic logic [4:0] pat_msb(input pat_sel_e s);
        case (s)
            PAT_P7:  return 5'd6;
            PAT_P15: return 5'd14;
            PAT_P23: return 5'd22;
            default: return 5'd30;
        endcase
    endfunction

    // history index of the second tap
    function automatic logic [4:0] pat_tap(input pat_sel_e s);
        case (s)
            PAT_P7:  return 5'd5;
            PAT_P15: return 5'd13;
            PAT_P23: return 5'd17;
            default: return 5'd27;
        endcase
    endfunction

    function automatic logic [5:0] pat_len(input pat_sel_e s);
        return {1'b0, pat_msb(s)} + 6'd1;
    endfunction

    function automatic logic [HIST_W-1:0] pat_period(input pat_sel_e s);
        case (s)
            PAT_P7:  return 31'd127;
            PAT_P15: return 31'd32767;
            PAT_P23: return 31'd8388607;
            default: return 31'h7FFF_FFFF;
        endcase
    endfunction

    function automatic logic [HIST_W-1:0] pat_mask(input pat_sel_e s);
        case (s)
            PAT_P7:  return 31'h0000_007F;
            PAT_P15: return 31'h0000_7FFF;
            PAT_P23: return 31'h007F_FFFF;
            default: return 31'h7FFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/prbs_predictor.sv
module prbs_predictor
    import prbs_det_pkg::*;
(
    input  logic [HIST_W-1:0] hist,
    input  pat_sel_e          sel,
    output pred_t             pred
);
    logic [HIST_W-1:0] mask;
    logic [HIST_W-1:0] hit;

    assign mask = pat_mask(sel);

    // bits above the pattern order never block the all-ones anchor
    generate
        for (genvar i = 0; i < HIST_W; i++) begin : g_anchor
            assign hit[i] = hist[i] | ~mask[i];
        end
    endgenerate

    assign pred.exp_bit = hist[pat_msb(sel)] ^ hist[pat_tap(sel)];
    assign pred.anchor  = &hit;
endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window #(
    parameter int WIN = 64,
    parameter int THR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic step,
    input  logic err,
    output logic over
);
    localparam int CW = $clog2(WIN + 2);

    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_nxt;

    assign cnt_nxt = cnt_q + CW'(err) - CW'(hist_q[WIN-1]);
    assign over    = step && (cnt_nxt > CW'(THR));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            hist_q <= {hist_q[WIN-2:0], err};
            cnt_q  <= cnt_nxt;
        end
    end
endmodule

// File: rtl/prbs_sync_ctrl.sv
module prbs_sync_ctrl
    import prbs_det_pkg::*;
#(
    parameter int LOCK_RUN = 64,
    parameter int WIN      = 64,
    parameter int LOSS_THR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  pat_sel_e sel,
    input  logic     in_valid,
    input  logic     in_bit,
    output logic     locked,
    output logic     cmp_step,
    output logic     cmp_err,
    output logic     anchor,
    output logic     lost_pulse
);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam int FILL_W = 6;

    sync_st_e          st_q;
    pat_sel_e          sel_q;
    logic [HIST_W-1:0] hist_q;
    logic [FILL_W-1:0] fill_q;
    logic [RUN_W-1:0]  run_q;
    logic              lost_q;

    pred_t pred;
    logic  sel_chg;
    logic  filled;
    logic  mism;
    logic  win_over;
    logic  drop;

    prbs_predictor u_pred (
        .hist (hist_q),
        .sel  (sel),
        .pred (pred)
    );

    assign sel_chg  = (sel != sel_q);
    assign filled   = (fill_q == pat_len(sel));
    assign mism     = in_bit ^ pred.exp_bit;
    assign cmp_step = in_valid && (st_q == ST_LOCK) && !sel_chg;
    assign cmp_err  = cmp_step && mism;
    assign drop     = cmp_step && win_over;

    prbs_err_window #(
        .WIN (WIN),
        .THR (LOSS_THR)
    ) u_win (
        .clk   (clk),
        .rst   (rst),
        .flush (st_q != ST_LOCK),
        .step  (cmp_step),
        .err   (cmp_err),
        .over  (win_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_ACQ;
            sel_q  <= sel;
            hist_q <= '1;
            fill_q <= '0;
            run_q  <= '0;
            lost_q <= 1'b0;
        end else begin
            sel_q  <= sel;
            lost_q <= drop;
            if (sel_chg) begin
                st_q   <= ST_ACQ;
                fill_q <= '0;
                run_q  <= '0;
            end else if (in_valid) begin
                if (st_q == ST_ACQ) begin
                    hist_q <= {hist_q[HIST_W-2:0], in_bit};
                    if (!filled) begin
                        fill_q <= fill_q + 1'b1;
                    end else if (mism) begin
                        run_q <= '0;
                    end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                        st_q  <= ST_LOCK;
                        run_q <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end else begin
                    hist_q <= {hist_q[HIST_W-2:0], pred.exp_bit};
                    if (drop) begin
                        st_q   <= ST_ACQ;
                        fill_q <= '0;
                        run_q  <= '0;
                    end
                end
            end
        end
    end

    assign locked     = (st_q == ST_LOCK);
    assign anchor     = pred.anchor;
    assign lost_pulse = lost_q;
endmodule

// File: rtl/prbs_sat_counter.sv
module prbs_sat_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc && (q != {W{1'b1}})) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/prbs_pos_track.sv
module prbs_pos_track
    import prbs_det_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pat_sel_e          sel,
    input  logic              step,
    input  logic              anchor,
    input  logic              cap,
    output logic [HIST_W-1:0] err_pos
);
    logic [HIST_W-1:0] pos_q;
    logic [HIST_W-1:0] pos_nxt;
    logic [HIST_W-1:0] last;

    assign last = pat_period(sel) - 1'b1;

    always_comb begin
        if (anchor || (pos_q >= last)) begin
            pos_nxt = '0;
        end else begin
            pos_nxt = pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            err_pos <= '0;
        end else begin
            if (step) pos_q <= pos_nxt;
            if (cap)  err_pos <= pos_nxt;
        end
    end
endmodule

// File: rtl/prbs_err_det.sv
module prbs_err_det
    import prbs_det_pkg::*;
#(
    parameter int CNT_W    = 48,
    parameter int LOCK_RUN = 64,
    parameter int WIN      = 64,
    parameter int LOSS_THR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic              clr_cnt,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic              locked,
    output logic              sync_lost,
    output logic              err_flag,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [HIST_W-1:0] err_pos
);
    localparam int N_CNT = 2;

    pat_sel_e   sel_e;
    logic       cmp_step;
    logic       cmp_err;
    logic       anchor;
    logic       err_q;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    assign sel_e = pat_sel_e'(sel);

    prbs_sync_ctrl #(
        .LOCK_RUN (LOCK_RUN),
        .WIN      (WIN),
        .LOSS_THR (LOSS_THR)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel_e),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .locked     (locked),
        .cmp_step   (cmp_step),
        .cmp_err    (cmp_err),
        .anchor     (anchor),
        .lost_pulse (sync_lost)
    );

    prbs_pos_track u_pos (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_e),
        .step    (in_valid),
        .anchor  (anchor),
        .cap     (cmp_err),
        .err_pos (err_pos)
    );

    assign cnt_inc = {cmp_err, cmp_step};

    generate
        for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
            prbs_sat_counter #(.W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .clr (clr_cnt),
                .inc (cnt_inc[g]),
                .q   (cnt_val[g])
            );
        end
    endgenerate

    assign bit_cnt = cnt_val[0];
    assign err_cnt = cnt_val[1];

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= cmp_err;
    end

    assign err_flag = err_q;
endmodule

// File: rtl/prbs_err_det_chk.sv
module prbs_err_det_chk
    import prbs_det_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        sel,
    input logic              clr_cnt,
    input logic              locked,
    input logic              sync_lost,
    input logic              err_flag,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [CNT_W-1:0]  err_cnt,
    input logic [HIST_W-1:0] err_pos
);
    a_r5_hold_unlocked: assert property (@(posedge clk) disable iff (rst)
        (!locked && !clr_cnt) |=> ($stable(bit_cnt) && $stable(err_cnt)));

    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        !clr_cnt |=> ((bit_cnt == $past(bit_cnt)) || (bit_cnt == $past(bit_cnt) + 1'b1)));

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        clr_cnt |=> ((bit_cnt == '0) && (err_cnt == '0)));

    a_r8_lost_pulse: assert property (@(posedge clk) disable iff (rst)
        sync_lost |-> (!locked && $past(locked)));

    a_r4_err_when_locked: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> $past(locked));

    a_r5_err_counted: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> ((err_cnt != $past(err_cnt)) || $past(clr_cnt) || (&$past(err_cnt))));

    a_r9_pos_range: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (err_pos < pat_period(pat_sel_e'($past(sel)))));
endmodule

bind prbs_err_det prbs_err_det_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .clr_cnt   (clr_cnt),
    .locked    (locked),
    .sync_lost (sync_lost),
    .err_flag  (err_flag),
    .bit_cnt   (bit_cnt),
    .err_cnt   (err_cnt),
    .err_pos   (err_pos)
);

// File: tb/prbs_err_det_tb.sv
module prbs_err_det_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 48;
    localparam int SW  = 4;
    localparam int NV  = 8;

    typedef struct packed {
        logic [1:0] sel;
        int         post;
        int         start;
        int         nerr;
        int         gap;
        logic       exp_lock;
        int         exp_err;
        int         exp_bits;
    } vec_t;

    // sel, bits after lock, first error, error count, spacing, lock, errs, bits
    localparam vec_t VECS [NV] = '{
        '{2'd0, 200,  0,  0,  1, 1'b1,  0, 200},
        '{2'd0, 200, 10,  5, 30, 1'b1,  5, 200},
        '{2'd0, 200,  5, 16,  2, 1'b1, 16, 200},
        '{2'd0, 200,  5, 17,  2, 1'b1, 17, 129},
        '{2'd1, 100, 50,  3,  7, 1'b1,  3, 100},
        '{2'd2, 100,  0,  1,  1, 1'b1,  1, 100},
        '{2'd3, 100, 99,  1,  1, 1'b1,  1, 100},
        '{2'd0, 200,  0, 17,  4, 1'b1, 17, 200}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] sel = 2'd0;
    logic clr_cnt = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;

    logic          locked, sync_lost, err_flag;
    logic [CW-1:0] bit_cnt, err_cnt;
    logic [30:0]   err_pos;
    logic          s_locked, s_lost, s_flag;
    logic [SW-1:0] s_bits, s_errs;
    logic [30:0]   s_pos;

    int n_chk = 0;
    int n_err = 0;

    logic [30:0] gs;
    int  gm, gt, glen;
    longint gidx;
    vec_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_err_det #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .clr_cnt(clr_cnt),
        .in_valid(in_valid), .in_bit(in_bit),
        .locked(locked), .sync_lost(sync_lost), .err_flag(err_flag),
        .bit_cnt(bit_cnt), .err_cnt(err_cnt), .err_pos(err_pos)
    );

    prbs_err_det #(.CNT_W(SW)) u_sat (
        .clk(clk), .rst(rst), .sel(sel), .clr_cnt(clr_cnt),
        .in_valid(in_valid), .in_bit(in_bit),
        .locked(s_locked), .sync_lost(s_lost), .err_flag(s_flag),
        .bit_cnt(s_bits), .err_cnt(s_errs), .err_pos(s_pos)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic b);
        in_valid = v;
        in_bit   = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic gen_init(input logic [1:0] s);
        case (s)
            2'd0: begin glen = 7;  gt = 5;  end
            2'd1: begin glen = 15; gt = 13; end
            2'd2: begin glen = 23; gt = 17; end
            default: begin glen = 31; gt = 27; end
        endcase
        gm   = glen - 1;
        gs   = '1;
        gidx = 0;
    endtask

    // R1: pattern model b[n] = b[n-order] ^ b[n-tap]
    task automatic send(input logic flip);
        logic b;
        b  = gs[gm] ^ gs[gt];
        gs = {gs[29:0], b};
        gidx++;
        step(1'b1, b ^ flip);
    endtask

    task automatic send_clean(input int n);
        for (int i = 0; i < n; i++) send(1'b0);
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst = 1'b1;
        sel = s;
        clr_cnt = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        gen_init(s);
    endtask

    function automatic longint period_of(input int len);
        return (longint'(1) << len) - 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1;
        // ---- R11 reset state
        do_reset(2'd0);
        check("R11 locked", locked, 0);
        check("R11 sync_lost", sync_lost, 0);
        check("R11 err_flag", err_flag, 0);
        check("R11 bit_cnt", bit_cnt, 0);
        check("R11 err_cnt", err_cnt, 0);
        check("R11 err_pos", err_pos, 0);

        // ---- R2 lock instant: 7 fill + 64 matches
        send_clean(70);
        check("R2 not yet locked at bit 70", locked, 0);
        send_clean(1);
        check("R2 locked at bit 71", locked, 1);
        check("R2 nothing counted yet", bit_cnt, 0);

        // ---- R5 gaps in valid do not count
        send_clean(5);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check("R5 bit_cnt ignores invalid", bit_cnt, 5);
        check("R5 err_cnt ignores invalid", err_cnt, 0);

        // ---- R9 / R4 one error, position and pulse
        send(1'b1);
        check("R9 err_flag pulse", err_flag, 1);
        check("R4 single error counted", err_cnt, 1);
        check("R9 err_pos", err_pos, (gidx - 1) % 127);
        send(1'b0);
        check("R9 err_flag clears", err_flag, 0);
        check("R4 no error propagation", err_cnt, 1);

        // ---- R6 clear beats increment
        clr_cnt = 1'b1;
        send(1'b0);
        clr_cnt = 1'b0;
        check("R6 bit_cnt cleared", bit_cnt, 0);
        check("R6 err_cnt cleared", err_cnt, 0);

        // ---- R8 loss of lock at the 17th dense error
        send_clean(64);
        for (int i = 0; i < 16; i++) send(1'b1);
        check("R8 16 errors keep lock", locked, 1);
        check("R8 no pulse at 16", sync_lost, 0);
        send(1'b1);
        check("R8 17th error drops lock", locked, 0);
        check("R8 sync_lost pulse", sync_lost, 1);
        check("R8 bits counted through drop", bit_cnt, 81);
        check("R8 errors counted", err_cnt, 17);
        step(1'b0, 1'b0);
        check("R8 pulse is one cycle", sync_lost, 0);

        // ---- R3 error during acquisition delays lock
        do_reset(2'd0);
        send_clean(20);
        send(1'b1);
        send_clean(70);
        check("R3 not locked at bit 91", locked, 0);
        send_clean(1);
        check("R3 locked at bit 92", locked, 1);

        // ---- R10 select change restarts acquisition
        sel = 2'd1;
        step(1'b0, 1'b0);
        check("R10 sel change drops lock", locked, 0);

        // ---- R7 saturation on a narrow instance
        do_reset(2'd0);
        send_clean(71);
        for (int i = 0; i < 64; i++) send((i % 4) == 0);
        check("R7 wide bit_cnt", bit_cnt, 64);
        check("R7 wide err_cnt", err_cnt, 16);
        check("R7 narrow bit_cnt saturates", s_bits, 15);
        check("R7 narrow err_cnt saturates", s_errs, 15);

        // ---- table: R1 R4 R5 R8 R9 across patterns
        for (int r = 0; r < NV; r++) begin
            cur = VECS[r];
            do_reset(cur.sel);
            send_clean(glen + 64);
            for (int off = 0; off < cur.post; off++) begin
                send((cur.nerr > 0) && (off >= cur.start) &&
                     (((off - cur.start) % cur.gap) == 0) &&
                     (((off - cur.start) / cur.gap) < cur.nerr));
            end
            check($sformatf("R1 row %0d locked", r), locked, cur.exp_lock);
            check($sformatf("R5 row %0d bit_cnt", r), bit_cnt, cur.exp_bits);
            check($sformatf("R8 row %0d err_cnt", r), err_cnt, cur.exp_err);
            if (cur.nerr > 0) begin
                check($sformatf("R9 row %0d err_pos", r), err_pos,
                      (longint'(glen + 64 + cur.start + (cur.nerr - 1) * cur.gap))
                      % period_of(glen));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule